// File: doc/BRIEF.md
# Power-Capped Self-Test Session Sequencer

This controller runs a fixed set of on-chip self-tests as a short series of sessions. The tests of one session run at the same time. Each test has a pattern generator feeding its logic under test and a signature register collecting the responses. The sequencer drives a one-cycle seed pulse and a run enable to each test's generator and analyzer. Each test's enable drops when that test's own cycle budget is used up. The session ends when its longest member finishes, and the next session then loads.

Every session is checked against a power ceiling when it is loaded. If a session's summed test power is over the ceiling, the run aborts with an error flag and that session's tests are never enabled. A clean run ends with a one-cycle completion pulse. At that point the pass flag is the AND of the per-test pass inputs, each taken in the final enabled cycle of its test.

With the default parameters there are six tests (power, length in cycles): A=(2,100), B=(1,10), C=(1,10), D=(1,5), E=(2,10), F=(1,100). The ceiling is 4 units. The sessions run in the order {C,D}, {B,E}, {A,F}, so the run lasts 120 test cycles plus one load cycle per session. Test k is bit k-1 of every per-test vector (A is bit 0, F is bit 5). Elaboration rejects a session table in which a test appears in more than one session or in none. It also rejects a table in which two tests that share a pattern-generator or analyzer resource are placed in the same session.

Top module: `bist_session_seq`

## Requirements
- R1: Sessions run in table order. With the defaults, C and D are first enabled 1 edge after the edge that samples `start`, B and E 12 edges after it, and A and F 23 edges after it. No test outside the current session is ever enabled.
- R2: In one run, every test's `run_en` bit is high for exactly that test's length: A=100, B=10, C=10, D=5, E=10, F=100 cycles.
- R3: A session loads only after every enable of the previous session is low, with one load cycle between sessions.
- R4: The summed power of the tests enabled in any cycle never exceeds `POWER_BUDGET`.
- R5: If a session's summed power exceeds `POWER_BUDGET` when it loads, `err` rises, `busy` falls and the run aborts. None of that session's tests or any later test is enabled, and `done` does not pulse. `err` clears on the next accepted `start`.
- R6: Each test's `seed_ld` bit pulses high for exactly one cycle per run, in the first cycle its `run_en` bit is high.
- R7: When `done` is high, `pass` is the AND of `test_pass[i]` over all tests, each sampled in the last cycle that test's `run_en` bit is high. `test_pass` at any other time has no effect.
- R8: `done` is high for exactly one cycle, 123 edges after the edge that samples `start` (the sum of the session lengths plus one load cycle per session, with the defaults).
- R9: A `start` pulse while `busy` is high is ignored and does not change the timing of the run.
- R10: A synchronous reset returns the block to idle, with `run_en`, `seed_ld`, `busy`, `done`, `err` and `pass` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle |
| test_pass | input | NUM_TESTS | Per-test pass flags from the signature analyzers |
| run_en | output | NUM_TESTS | Per-test enable to the pattern generator and the analyzer |
| seed_ld | output | NUM_TESTS | One-cycle seed/clear pulse at the start of each test |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a clean run |
| pass | output | 1 | Accumulated result, valid with `done` |
| err | output | 1 | Power-ceiling violation; the run was aborted |

## Verification
Full runs are made with constant all-pass and single-failure `test_pass` patterns; these show whether each test's flag actually reaches the result. A pattern that passes only while a test is enabled, and its inverse, tell sampling at the final enabled cycle apart from sampling at any other time. Per-test enable counts and first-rise edges separate the session order and per-test lengths from a design that enables all tests together or runs them one by one. A second instance with a tighter ceiling, a mid-run reset and a `start` pulse injected while busy cover the abort, reset and ignore cases.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_RUN  = 2'd2,
      ST_DONE = 2'd3
   } seq_state_t;
endpackage

// File: rtl/bss_sess_table.sv
// Decodes the current session: member mask, summed power, longest length.
module bss_sess_table #(
   parameter int unsigned NUM_TESTS = 6,
   parameter int unsigned NUM_SESS  = 3,
   parameter int unsigned PWR_W     = 4,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned SUM_W     = 7,
   parameter int unsigned SIDX_W    = 2,
   parameter logic [NUM_TESTS*PWR_W-1:0]    TEST_PWR  = '0,
   parameter logic [NUM_TESTS*LEN_W-1:0]    TEST_LEN  = '0,
   parameter logic [NUM_SESS*NUM_TESTS-1:0] SESS_MASK = '0
) (
   input  logic [SIDX_W-1:0]    sess_idx,
   output logic [NUM_TESTS-1:0] mask,
   output logic [SUM_W-1:0]     pwr_sum,
   output logic [LEN_W-1:0]     max_len
);
   always_comb begin
      mask = '0;
      for (int s = 0; s < NUM_SESS; s++) begin
         if (sess_idx == SIDX_W'(s)) mask = SESS_MASK[s*NUM_TESTS +: NUM_TESTS];
      end
   end

   always_comb begin
      pwr_sum = '0;
      max_len = '0;
      for (int t = 0; t < NUM_TESTS; t++) begin
         if (mask[t]) begin
            pwr_sum = pwr_sum + SUM_W'(TEST_PWR[t*PWR_W +: PWR_W]);
            if (TEST_LEN[t*LEN_W +: LEN_W] > max_len) max_len = TEST_LEN[t*LEN_W +: LEN_W];
         end
      end
   end
endmodule

// File: rtl/bss_lane.sv
// One test lane: seed pulse and run enable held for the test's own length.
module bss_lane #(
   parameter int unsigned LEN_W = 8,
   parameter int unsigned LEN   = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             arm,
   input  logic             run,
   input  logic [LEN_W-1:0] cnt,
   input  logic             pass_in,
   output logic             en,
   output logic             seed,
   output logic             fail_fin
);
   localparam logic [LEN_W-1:0] LAST = LEN_W'(LEN);

   logic last_cyc;
   assign last_cyc = run && en && (cnt == LAST);
   assign fail_fin = last_cyc && !pass_in;

   always_ff @(posedge clk) begin
      if (rst) begin
         en   <= 1'b0;
         seed <= 1'b0;
      end else begin
         seed <= arm;
         if (arm)           en <= 1'b1;
         else if (last_cyc) en <= 1'b0;
      end
   end
endmodule

// File: rtl/bss_ctrl.sv
// Run sequencing: load/budget check, cycle count, session advance, result.
module bss_ctrl
   import bist_seq_pkg::*;
#(
   parameter int unsigned NUM_SESS     = 3,
   parameter int unsigned SIDX_W       = 2,
   parameter int unsigned LEN_W        = 8,
   parameter int unsigned SUM_W        = 7,
   parameter int unsigned POWER_BUDGET = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [SUM_W-1:0]  pwr_sum,
   input  logic [LEN_W-1:0]  max_len,
   input  logic              any_fail,
   output logic [SIDX_W-1:0] sess_idx,
   output logic [LEN_W-1:0]  cnt,
   output logic              arm,
   output logic              run,
   output logic              busy,
   output logic              done,
   output logic              pass,
   output logic              err
);
   localparam logic [SIDX_W-1:0] LAST_SESS = SIDX_W'(NUM_SESS - 1);

   seq_state_t state;
   logic       fits;

   assign fits = (32'(pwr_sum) <= POWER_BUDGET);
   assign arm  = (state == ST_LOAD) && fits;
   assign run  = (state == ST_RUN);
   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         sess_idx <= '0;
         cnt      <= '0;
         err      <= 1'b0;
         pass     <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state    <= ST_LOAD;
               sess_idx <= '0;
               err      <= 1'b0;
               pass     <= 1'b1;
            end
            ST_LOAD: if (fits) begin
               cnt   <= LEN_W'(1);
               state <= ST_RUN;
            end else begin
               err   <= 1'b1;
               pass  <= 1'b0;
               state <= ST_IDLE;
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (any_fail) pass <= 1'b0;
               if (cnt == max_len) begin
                  if (sess_idx == LAST_SESS) state <= ST_DONE;
                  else begin
                     sess_idx <= sess_idx + 1'b1;
                     state    <= ST_LOAD;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bist_session_seq.sv
module bist_session_seq #(
   parameter int unsigned NUM_TESTS    = 6,
   parameter int unsigned NUM_SESS     = 3,
   parameter int unsigned PWR_W        = 4,
   parameter int unsigned LEN_W        = 8,
   parameter int unsigned RES_W        = 9,
   parameter int unsigned POWER_BUDGET = 4,
   // per-test fields, test 0 in the low slice
   parameter logic [NUM_TESTS*PWR_W-1:0] TEST_PWR =
      {4'd1, 4'd2, 4'd1, 4'd1, 4'd1, 4'd2},
   parameter logic [NUM_TESTS*LEN_W-1:0] TEST_LEN =
      {8'd100, 8'd10, 8'd5, 8'd10, 8'd10, 8'd100},
   parameter logic [NUM_TESTS*RES_W-1:0] TEST_RES =
      {9'h014, 9'h101, 9'h0C0, 9'h030, 9'h00C, 9'h003},
   // session 0 in the low slice; run order is slice order
   parameter logic [NUM_SESS*NUM_TESTS-1:0] SESS_MASK =
      {6'b100001, 6'b010010, 6'b001100}
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [NUM_TESTS-1:0] test_pass,
   output logic [NUM_TESTS-1:0] run_en,
   output logic [NUM_TESTS-1:0] seed_ld,
   output logic                 busy,
   output logic                 done,
   output logic                 pass,
   output logic                 err
);
   localparam int unsigned SUM_W  = PWR_W + $clog2(NUM_TESTS + 1);
   localparam int unsigned SIDX_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1;

   function automatic bit members_ok();
      for (int t = 0; t < NUM_TESTS; t++) begin
         int hits = 0;
         for (int s = 0; s < NUM_SESS; s++) hits += int'(SESS_MASK[s*NUM_TESTS + t]);
         if (hits != 1) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic bit resources_ok();
      for (int s = 0; s < NUM_SESS; s++)
         for (int i = 0; i < NUM_TESTS; i++)
            for (int j = i + 1; j < NUM_TESTS; j++)
               if (SESS_MASK[s*NUM_TESTS + i] && SESS_MASK[s*NUM_TESTS + j] &&
                   ((TEST_RES[i*RES_W +: RES_W] & TEST_RES[j*RES_W +: RES_W]) != '0))
                  return 1'b0;
      return 1'b1;
   endfunction

   function automatic bit lengths_ok();
      for (int t = 0; t < NUM_TESTS; t++)
         if (TEST_LEN[t*LEN_W +: LEN_W] == '0) return 1'b0;
      return 1'b1;
   endfunction

   generate
      if (NUM_TESTS < 1 || NUM_SESS < 1) begin : g_bad_size
         $error("bist_session_seq: need at least one test and one session");
      end
      if (!members_ok()) begin : g_bad_members
         $error("bist_session_seq: each test must belong to exactly one session");
      end
      if (!resources_ok()) begin : g_bad_resources
         $error("bist_session_seq: tests sharing a resource placed in one session");
      end
      if (!lengths_ok()) begin : g_bad_length
         $error("bist_session_seq: test length of zero");
      end
   endgenerate

   logic [SIDX_W-1:0]    sess_idx;
   logic [NUM_TESTS-1:0] sess_mask;
   logic [SUM_W-1:0]     pwr_sum;
   logic [LEN_W-1:0]     max_len;
   logic [LEN_W-1:0]     cnt;
   logic                 arm, run;
   logic [NUM_TESTS-1:0] fail_fin;

   bss_sess_table #(
      .NUM_TESTS(NUM_TESTS), .NUM_SESS(NUM_SESS), .PWR_W(PWR_W), .LEN_W(LEN_W),
      .SUM_W(SUM_W), .SIDX_W(SIDX_W), .TEST_PWR(TEST_PWR), .TEST_LEN(TEST_LEN),
      .SESS_MASK(SESS_MASK)
   ) u_table (
      .sess_idx(sess_idx), .mask(sess_mask), .pwr_sum(pwr_sum), .max_len(max_len)
   );

   bss_ctrl #(
      .NUM_SESS(NUM_SESS), .SIDX_W(SIDX_W), .LEN_W(LEN_W), .SUM_W(SUM_W),
      .POWER_BUDGET(POWER_BUDGET)
   ) u_ctrl (
      .clk(clk), .rst(rst), .start(start), .pwr_sum(pwr_sum), .max_len(max_len),
      .any_fail(|fail_fin), .sess_idx(sess_idx), .cnt(cnt), .arm(arm), .run(run),
      .busy(busy), .done(done), .pass(pass), .err(err)
   );

   generate
      for (genvar t = 0; t < NUM_TESTS; t++) begin : g_lane
         bss_lane #(
            .LEN_W(LEN_W), .LEN(int'(TEST_LEN[t*LEN_W +: LEN_W]))
         ) u_lane (
            .clk(clk), .rst(rst), .arm(arm && sess_mask[t]), .run(run), .cnt(cnt),
            .pass_in(test_pass[t]), .en(run_en[t]), .seed(seed_ld[t]),
            .fail_fin(fail_fin[t])
         );
      end
   endgenerate
endmodule

// File: rtl/bist_session_seq_chk.sv
module bist_session_seq_chk #(
   parameter int unsigned NUM_TESTS    = 6,
   parameter int unsigned PWR_W        = 4,
   parameter int unsigned POWER_BUDGET = 4,
   parameter logic [NUM_TESTS*PWR_W-1:0] TEST_PWR = '0
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_TESTS-1:0] run_en,
   input logic [NUM_TESTS-1:0] seed_ld,
   input logic [NUM_TESTS-1:0] sess_mask,
   input logic                 busy,
   input logic                 done,
   input logic                 err
);
   function automatic int unsigned power_of(logic [NUM_TESTS-1:0] m);
      int unsigned acc = 0;
      for (int t = 0; t < NUM_TESTS; t++)
         if (m[t]) acc += int'(TEST_PWR[t*PWR_W +: PWR_W]);
      return acc;
   endfunction

   a_r1_members_only: assert property (@(posedge clk) disable iff (rst)
      (run_en & ~sess_mask) == '0);

   a_r3_gap_before_load: assert property (@(posedge clk) disable iff (rst)
      (seed_ld != '0) |-> ($past(run_en) == '0));

   a_r4_power_cap: assert property (@(posedge clk) disable iff (rst)
      power_of(run_en) <= POWER_BUDGET);

   a_r5_abort_quiet: assert property (@(posedge clk) disable iff (rst)
      err |-> (run_en == '0 && !done));

   a_r6_seed_single: assert property (@(posedge clk) disable iff (rst)
      (seed_ld != '0) |=> (seed_ld == '0));

   a_r6_seed_with_en: assert property (@(posedge clk) disable iff (rst)
      (seed_ld & ~run_en) == '0);

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (run_en == '0 && !busy && !done && !err));
endmodule

bind bist_session_seq bist_session_seq_chk #(
   .NUM_TESTS(NUM_TESTS), .PWR_W(PWR_W), .POWER_BUDGET(POWER_BUDGET), .TEST_PWR(TEST_PWR)
) u_chk (
   .clk(clk), .rst(rst), .run_en(run_en), .seed_ld(seed_ld), .sess_mask(sess_mask),
   .busy(busy), .done(done), .err(err)
);

// File: tb/bist_session_seq_test.sv
`timescale 1ns/1ps
module bist_session_seq_test;
   localparam int NT = 6;
   localparam int NS = 3;
   localparam int LEN [NT] = '{100, 10, 10, 5, 10, 100};
   localparam int PWR [NT] = '{2, 1, 1, 1, 2, 1};
   localparam int SESS_OF [NT] = '{2, 1, 0, 0, 1, 2};
   // {mode[1:0], constant pass vector[5:0], expected pass}
   // mode 0: constant, 1: pass only while enabled, 2: pass only while disabled
   localparam logic [8:0] VEC_TAB [6] = '{
      {2'd0, 6'b111111, 1'b1},
      {2'd0, 6'b111110, 1'b0},
      {2'd0, 6'b011111, 1'b0},
      {2'd0, 6'b101111, 1'b0},
      {2'd1, 6'b000000, 1'b1},
      {2'd2, 6'b000000, 1'b0}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0, start2 = 1'b0;
   logic [1:0] tp_mode = 2'd0;
   logic [NT-1:0] tp_vec = '1;
   logic [NT-1:0] test_pass, run_en, seed_ld, run_en2, seed_ld2;
   logic busy, done, pass, err, busy2, done2, pass2, err2;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   always_comb begin
      case (tp_mode)
         2'd1:    test_pass = run_en;
         2'd2:    test_pass = ~run_en;
         default: test_pass = tp_vec;
      endcase
   end

   bist_session_seq uut (
      .clk(clk), .rst(rst), .start(start), .test_pass(test_pass), .run_en(run_en),
      .seed_ld(seed_ld), .busy(busy), .done(done), .pass(pass), .err(err)
   );

   bist_session_seq #(.POWER_BUDGET(2)) uut_tight (
      .clk(clk), .rst(rst), .start(start2), .test_pass('1), .run_en(run_en2),
      .seed_ld(seed_ld2), .busy(busy2), .done(done2), .pass(pass2), .err(err2)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int sess_len(input int s);
      int m = 0;
      for (int t = 0; t < NT; t++) if (SESS_OF[t] == s && LEN[t] > m) m = LEN[t];
      return m;
   endfunction

   function automatic int exp_rise(input int t);
      int e = 1;
      for (int s = 0; s < SESS_OF[t]; s++) e += sess_len(s) + 1;
      return e;
   endfunction

   function automatic int exp_done();
      int e = 0;
      for (int s = 0; s < NS; s++) e += sess_len(s) + 1;
      return e;
   endfunction

   task automatic full_run(input logic [1:0] mode, input logic [NT-1:0] vec,
                           input bit exp_pass);
      int en_cnt [NT];
      int seed_cnt [NT];
      int rise_n [NT];
      int n, done_n, p;
      bit pwr_bad, pass_seen;
      logic [NT-1:0] prev;
      for (int t = 0; t < NT; t++) begin en_cnt[t] = 0; seed_cnt[t] = 0; rise_n[t] = -1; end
      tp_mode = mode; tp_vec = vec;
      pwr_bad = 0; pass_seen = 0; done_n = -1; n = 0;
      @(negedge clk); start = 1'b1;
      @(posedge clk);
      @(negedge clk); start = 1'b0;
      prev = run_en;
      while (n < 400 && done_n < 0) begin
         @(posedge clk); n++;
         @(negedge clk);
         start = (n == 60);   // R9: pulse while busy, must be ignored
         p = 0;
         for (int t = 0; t < NT; t++) begin
            if (run_en[t]) begin en_cnt[t]++; p += PWR[t]; end
            if (run_en[t] && !prev[t] && rise_n[t] < 0) rise_n[t] = n;
            if (seed_ld[t]) seed_cnt[t]++;
         end
         if (p > 4) pwr_bad = 1;
         if (done) begin done_n = n; pass_seen = pass; end
         prev = run_en;
      end
      start = 1'b0;
      chk(done_n == exp_done(), "R8/R9", "done edge", done_n, exp_done());
      chk(pass_seen == exp_pass, "R7", "pass at done", int'(pass_seen), int'(exp_pass));
      chk(!pwr_bad, "R4", "power over budget seen", int'(pwr_bad), 0);
      for (int t = 0; t < NT; t++) begin
         chk(en_cnt[t] == LEN[t], "R2", $sformatf("enable cycles test %0d", t), en_cnt[t], LEN[t]);
         chk(rise_n[t] == exp_rise(t), "R1/R3", $sformatf("first enable edge test %0d", t),
             rise_n[t], exp_rise(t));
         chk(seed_cnt[t] == 1, "R6", $sformatf("seed pulses test %0d", t), seed_cnt[t], 1);
      end
      @(posedge clk);
      @(negedge clk);
      chk(!done, "R8", "done one cycle wide", int'(done), 0);
      chk(!busy, "R8", "idle after done", int'(busy), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      bit seen_done, seen_en;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R10: reset state
      chk(run_en == '0 && seed_ld == '0, "R10", "enables after reset", int'(run_en), 0);
      chk(!busy && !done && !err && !pass, "R10", "flags after reset",
          int'({busy, done, err, pass}), 0);

      // main function over the stimulus table
      foreach (VEC_TAB[i]) full_run(VEC_TAB[i][8:7], VEC_TAB[i][6:1], VEC_TAB[i][0]);

      // R10: reset in the middle of a run
      @(negedge clk); start = 1'b1; tp_mode = 2'd0; tp_vec = '1;
      @(posedge clk);
      @(negedge clk); start = 1'b0;
      repeat (30) @(posedge clk);
      @(negedge clk);
      chk(run_en != '0, "R10", "run active before reset", int'(run_en != '0), 1);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk); rst = 1'b0;
      chk(run_en == '0, "R10", "enables after mid-run reset", int'(run_en), 0);
      chk(!busy && !done && !pass, "R10", "flags after mid-run reset",
          int'({busy, done, pass}), 0);
      full_run(2'd0, '1, 1'b1);

      // R5: tighter ceiling aborts at the second session
      @(negedge clk); start2 = 1'b1;
      @(posedge clk);
      @(negedge clk); start2 = 1'b0;
      chk(busy2 && !err2, "R5", "busy after start", int'({busy2, err2}), 2);
      seen_done = 0; seen_en = 0; n = 0;
      repeat (40) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (done2) seen_done = 1;
         if (run_en2[0] || run_en2[1] || run_en2[4] || run_en2[5]) seen_en = 1;
         if (n == 11) chk(!err2, "R5", "no error before over-budget load", int'(err2), 0);
         if (n == 12) chk(err2 && !busy2, "R5", "abort at over-budget load",
                          int'({err2, busy2}), 2);
      end
      chk(!seen_en, "R5", "over-budget tests enabled", int'(seen_en), 0);
      chk(!seen_done, "R5", "done after abort", int'(seen_done), 0);
      chk(err2 && run_en2 == '0, "R5", "error held, enables low",
          int'({err2, run_en2 == '0}), 3);
      @(negedge clk); start2 = 1'b1;
      @(posedge clk);
      @(negedge clk); start2 = 1'b0;
      chk(!err2 && busy2, "R5", "error cleared by new start", int'({err2, busy2}), 1);
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(err2, "R5", "second abort", int'(err2), 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule